// File: doc/BRIEF.md
# Converter Data-Ready and Mode Controller

This block is the digital control core of a sampling converter. It paces conversions with a parameterized period counter and drives an active-low ready flag toward the host. It sequences the converter through its run, halted, standby, power-down and oscillator-wake modes, under a combined synchronize/power-down pin and decoded serial commands. The analog modulator, the decimation filter and the serial shifter are outside it. The serial side supplies one-cycle command strobes and a strobe marking that the full 24-bit result has been shifted out.

The ready flag falls when a fresh result lands. It rises again when the host has read that result, or when the next result begins to be written. Pulsing the pin low and high restarts the conversion period. Holding the pin low for a set number of result periods powers the block down, and raising it again starts a fixed oscillator wake interval before conversions resume. The halt command stops conversion until a WAKEUP strobe, and so does standby, which keeps the oscillator and the optional clock output alive.

Top module: `cnv_ready_ctrl`

## Requirements
- R1: While `rst` is high, `drdy_n`=1, `mode_o`=0 (run), `conv_en`=1, `osc_en`=1, `sif_block`=0 and `clkout_en`=0. The first result makes `drdy_n` fall exactly CONV_CYC clock edges after the last edge with `rst` high.
- R2: In run mode with no reads, `drdy_n` repeats with period CONV_CYC. It is low for CONV_CYC-UPD_CYC cycles after each result and high for the UPD_CYC update cycles that end the period.
- R3: A `rd_done` strobe while `drdy_n` is low makes `drdy_n` high after that edge, and it stays high until the next result. If a result completes on the same edge, the result wins and `drdy_n` goes low.
- R4: When `sync_n` is sampled high at an edge after being sampled low, the period restarts at that edge and `drdy_n` is high. The next result arrives CONV_CYC edges later.
- R5: `sif_block` is high after every edge that samples `sync_n` low, and low otherwise. Command strobes sampled while `sync_n` is low have no effect.
- R6: The halt command (`cmd_sync`) in run mode enters mode 1 at that edge, with `conv_en`=0 and `drdy_n` held high. `cmd_wakeup` returns the block to run mode at the edge that samples it, and the next result comes CONV_CYC edges later.
- R7: `cmd_standby` in run mode enters mode 2, with `conv_en`=0, `osc_en`=1, and `clkout_en` following `clkout_sel` one edge late. `cmd_wakeup` exits as in R6.
- R8: If `sync_n` stays low from the first edge after a period restart, the PD_PERIODS-th result edge enters mode 3 (power-down) instead of delivering a result. In this mode `conv_en`, `osc_en` and `clkout_en` are 0 and `drdy_n` is 1.
- R9: In power-down, the first edge that samples `sync_n` high enters mode 4 (wake), with `osc_en`=1 and `conv_en`=`clkout_en`=0. Exactly WAKE_CYC edges later the block is in run mode, and its first result follows after CONV_CYC more edges.
- R10: `cmd_wakeup` has no effect in run mode. `cmd_sync` and `cmd_standby` have no effect in modes 1 and 2.
- R11: The power-down count clears whenever `sync_n` is high. A low stretch covering PD_PERIODS-1 result edges, followed by a high sample, acts as a plain synchronization (R4) and not a power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Combined synchronize / power-down pin, active low |
| cmd_sync | input | 1 | Decoded halt command strobe |
| cmd_wakeup | input | 1 | Strobe on the first serial clock of a WAKEUP command |
| cmd_standby | input | 1 | Decoded standby command strobe |
| rd_done | input | 1 | All 24 result bits have been shifted out |
| clkout_sel | input | 1 | Clock output enabled by configuration |
| drdy_n | output | 1 | Result ready flag, active low |
| conv_en | output | 1 | Conversion engine enable |
| osc_en | output | 1 | Oscillator enable |
| clkout_en | output | 1 | Clock output driver enable |
| sif_block | output | 1 | Serial interface blocked |
| mode_o | output | 3 | Mode: 0 run, 1 halted, 2 standby, 3 power-down, 4 wake |

## Verification
Every mode and enable output changes on the edge that samples the command or pin level, so the bench reads them at the falling edge that follows. The ready flag falls CONV_CYC edges after any restarting edge (reset release, pin release, wakeup, end of the wake interval). After that it follows a cycle-by-cycle model that counts edges since the restart and latches random reads. The power-down and wake boundaries are probed one edge before and on the edge where they are due, at 20·CONV_CYC and WAKE_CYC edges respectively.

// File: rtl/cnv_ready_pkg.sv
package cnv_ready_pkg;

  typedef enum logic [2:0] {
    MODE_RUN       = 3'd0,
    MODE_SYNC_HALT = 3'd1,
    MODE_STANDBY   = 3'd2,
    MODE_POWERDOWN = 3'd3,
    MODE_WAKE_WAIT = 3'd4
  } cnv_mode_e;

endpackage

// File: rtl/cnv_period_timer.sv
// Conversion period counter: stands in for modulator and filter timing.
module cnv_period_timer #(
  parameter int unsigned CONV_CYC = 64,
  parameter int unsigned UPD_CYC  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_now,
  input  logic run_nxt,
  input  logic restart,
  output logic done,
  output logic upd_win
);

  localparam int unsigned CW = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CONV_CYC - 1);
  localparam logic [CW-1:0] UPD_LO   = CW'(CONV_CYC - UPD_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart || !run_nxt) begin
      cnt <= '0;
    end else if (cnt == CNT_LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // Result lands on the edge that ends the last count of the period.
  assign done    = run_now && (cnt == CNT_LAST);
  // Edges that place the flag into its update window.
  assign upd_win = run_now && (cnt >= UPD_LO) && (cnt < CNT_LAST);

endmodule

// File: rtl/cnv_mode_fsm.sv
// Mode sequencer: pin synchronization, commands, power-down and wake timing.
module cnv_mode_fsm
  import cnv_ready_pkg::*;
#(
  parameter int unsigned PD_PERIODS = 20,
  parameter int unsigned WAKE_CYC   = 8192
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sync_n,
  input  logic      cmd_sync,
  input  logic      cmd_wakeup,
  input  logic      cmd_standby,
  input  logic      done,
  output cnv_mode_e mode_q,
  output cnv_mode_e mode_nxt,
  output logic      restart
);

  localparam int unsigned PW = $clog2(PD_PERIODS + 1);
  localparam int unsigned WW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
  localparam logic [PW-1:0] PD_LAST   = PW'(PD_PERIODS - 1);
  localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CYC - 1);

  logic          sync_q;
  logic [PW-1:0] pd_cnt;
  logic [WW-1:0] wake_cnt;
  logic          pin_rise;
  logic          cmd_ok;
  logic          pd_hit;

  assign pin_rise = sync_n & ~sync_q;
  assign cmd_ok   = sync_n;
  assign pd_hit   = ~sync_n & done & (pd_cnt == PD_LAST);

  always_comb begin
    mode_nxt = mode_q;
    case (mode_q)
      MODE_RUN: begin
        if (pd_hit) begin
          mode_nxt = MODE_POWERDOWN;
        end else if (cmd_ok && cmd_standby) begin
          mode_nxt = MODE_STANDBY;
        end else if (cmd_ok && cmd_sync) begin
          mode_nxt = MODE_SYNC_HALT;
        end
      end
      MODE_SYNC_HALT, MODE_STANDBY: begin
        if (cmd_ok && cmd_wakeup) begin
          mode_nxt = MODE_RUN;
        end
      end
      MODE_POWERDOWN: begin
        if (sync_n) begin
          mode_nxt = MODE_WAKE_WAIT;
        end
      end
      MODE_WAKE_WAIT: begin
        if (wake_cnt == WAKE_LAST) begin
          mode_nxt = MODE_RUN;
        end
      end
      default: mode_nxt = MODE_RUN;
    endcase
  end

  // A period restarts on entry to run mode or on a pin release while running.
  assign restart = (mode_nxt == MODE_RUN) && ((mode_q != MODE_RUN) || pin_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= 1'b1;
      mode_q   <= MODE_RUN;
      pd_cnt   <= '0;
      wake_cnt <= '0;
    end else begin
      sync_q <= sync_n;
      mode_q <= mode_nxt;
      if ((mode_q != MODE_RUN) || sync_n) begin
        pd_cnt <= '0;
      end else if (done) begin
        pd_cnt <= pd_cnt + PW'(1);
      end
      if (mode_q != MODE_WAKE_WAIT) begin
        wake_cnt <= '0;
      end else begin
        wake_cnt <= wake_cnt + WW'(1);
      end
    end
  end

endmodule

// File: rtl/cnv_ready_flag.sv
// Active-low ready flag with result, update-window, read and restart rules.
module cnv_ready_flag (
  input  logic clk,
  input  logic rst,
  input  logic run_nxt,
  input  logic restart,
  input  logic done,
  input  logic upd_win,
  input  logic rd_done,
  output logic drdy_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      drdy_n <= 1'b1;
    end else if (!run_nxt || restart) begin
      drdy_n <= 1'b1;
    end else if (done) begin
      drdy_n <= 1'b0;
    end else if (upd_win || rd_done) begin
      drdy_n <= 1'b1;
    end
  end

endmodule

// File: rtl/cnv_ready_ctrl.sv
module cnv_ready_ctrl
  import cnv_ready_pkg::*;
#(
  parameter int unsigned CONV_CYC   = 64,
  parameter int unsigned UPD_CYC    = 4,
  parameter int unsigned PD_PERIODS = 20,
  parameter int unsigned WAKE_CYC   = 8192
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_n,
  input  logic       cmd_sync,
  input  logic       cmd_wakeup,
  input  logic       cmd_standby,
  input  logic       rd_done,
  input  logic       clkout_sel,
  output logic       drdy_n,
  output logic       conv_en,
  output logic       osc_en,
  output logic       clkout_en,
  output logic       sif_block,
  output logic [2:0] mode_o
);

  cnv_mode_e mode_q;
  cnv_mode_e mode_nxt;
  logic      restart;
  logic      done;
  logic      upd_win;
  logic      run_now;
  logic      run_nxt;
  logic      clk_alive_nxt;

  assign run_now       = (mode_q == MODE_RUN);
  assign run_nxt       = (mode_nxt == MODE_RUN);
  assign clk_alive_nxt = (mode_nxt == MODE_RUN) || (mode_nxt == MODE_SYNC_HALT) ||
                         (mode_nxt == MODE_STANDBY);

  cnv_mode_fsm #(
    .PD_PERIODS (PD_PERIODS),
    .WAKE_CYC   (WAKE_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .sync_n      (sync_n),
    .cmd_sync    (cmd_sync),
    .cmd_wakeup  (cmd_wakeup),
    .cmd_standby (cmd_standby),
    .done        (done),
    .mode_q      (mode_q),
    .mode_nxt    (mode_nxt),
    .restart     (restart)
  );

  cnv_period_timer #(
    .CONV_CYC (CONV_CYC),
    .UPD_CYC  (UPD_CYC)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run_now (run_now),
    .run_nxt (run_nxt),
    .restart (restart),
    .done    (done),
    .upd_win (upd_win)
  );

  cnv_ready_flag u_flag (
    .clk     (clk),
    .rst     (rst),
    .run_nxt (run_nxt),
    .restart (restart),
    .done    (done),
    .upd_win (upd_win),
    .rd_done (rd_done),
    .drdy_n  (drdy_n)
  );

  // Enables are registered from the next mode so they line up with mode_o.
  always_ff @(posedge clk) begin
    if (rst) begin
      conv_en   <= 1'b1;
      osc_en    <= 1'b1;
      clkout_en <= 1'b0;
      sif_block <= 1'b0;
    end else begin
      conv_en   <= run_nxt;
      osc_en    <= (mode_nxt != MODE_POWERDOWN);
      clkout_en <= clkout_sel && clk_alive_nxt;
      sif_block <= ~sync_n;
    end
  end

  assign mode_o = 3'(mode_q);

endmodule

// File: rtl/cnv_ready_ctrl_chk.sv
module cnv_ready_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       sync_n,
  input logic       rd_done,
  input logic       drdy_n,
  input logic       conv_en,
  input logic       osc_en,
  input logic       clkout_en,
  input logic       sif_block,
  input logic [2:0] mode_o
);

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst) (!drdy_n && rd_done) |=> drdy_n) else $error("read did not release flag"); // R3
  AST_PIN_BLOCK: assert property (@(posedge clk) disable iff (rst) !sync_n |=> sif_block) else $error("interface not blocked"); // R5
  AST_PIN_UNBLOCK: assert property (@(posedge clk) disable iff (rst) sync_n |=> !sif_block) else $error("interface stuck blocked"); // R5
  AST_HALT_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst) (!sync_n && (mode_o == 3'd1 || mode_o == 3'd2)) |=> (mode_o == $past(mode_o))) else $error("command taken while blocked"); // R5
  AST_IDLE_READY_HIGH: assert property (@(posedge clk) disable iff (rst) (mode_o != 3'd0) |-> (drdy_n && !conv_en)) else $error("flag low outside run"); // R6
  AST_PD_ALL_OFF: assert property (@(posedge clk) disable iff (rst) (mode_o == 3'd3) |-> (!osc_en && !clkout_en && !conv_en)) else $error("power-down enables"); // R8
  AST_PD_EXIT: assert property (@(posedge clk) disable iff (rst) (mode_o == 3'd3 && sync_n) |=> (mode_o == 3'd4)) else $error("power-down exit"); // R9
  AST_WAKE_OSC: assert property (@(posedge clk) disable iff (rst) (mode_o == 3'd4) |-> (osc_en && !clkout_en && !conv_en)) else $error("wake enables"); // R9
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst) mode_o <= 3'd4) else $error("illegal mode"); // R1

endmodule

bind cnv_ready_ctrl cnv_ready_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sync_n    (sync_n),
  .rd_done   (rd_done),
  .drdy_n    (drdy_n),
  .conv_en   (conv_en),
  .osc_en    (osc_en),
  .clkout_en (clkout_en),
  .sif_block (sif_block),
  .mode_o    (mode_o)
);

// File: tb/cnv_ready_ctrl_bench.sv
module cnv_ready_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int C  = 64;
  localparam int U  = 4;
  localparam int PD = 20;
  localparam int W  = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_n = 1'b1;
  logic cmd_sync = 1'b0;
  logic cmd_wakeup = 1'b0;
  logic cmd_standby = 1'b0;
  logic rd_done = 1'b0;
  logic clkout_sel = 1'b1;
  logic drdy_n, conv_en, osc_en, clkout_en, sif_block;
  logic [2:0] mode_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnv_ready_ctrl #(
    .CONV_CYC (C), .UPD_CYC (U), .PD_PERIODS (PD), .WAKE_CYC (W)
  ) u_cnv_ready_ctrl (
    .clk (clk), .rst (rst), .sync_n (sync_n), .cmd_sync (cmd_sync),
    .cmd_wakeup (cmd_wakeup), .cmd_standby (cmd_standby), .rd_done (rd_done),
    .clkout_sel (clkout_sel), .drdy_n (drdy_n), .conv_en (conv_en),
    .osc_en (osc_en), .clkout_en (clkout_en), .sif_block (sif_block), .mode_o (mode_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected flag level k edges after a period restart, with read latch lat.
  function automatic int exp_flag(input int k, input bit lat);
    if (k < C) return 1;
    if ((k % C) >= C - U) return 1;
    return lat ? 1 : 0;
  endfunction

  // Called at the falling edge right after a restarting edge.
  task automatic track(input int n, input int wk_at, input string tg);
    int k = 0;
    bit lat = 1'b0;
    bit r;
    for (int i = 0; i < n; i++) begin
      chk(lat ? {tg, " R3"} : tg, drdy_n, exp_flag(k, lat));
      r = ($urandom_range(0, 5) == 0);
      rd_done = r;
      cmd_wakeup = (i == wk_at);
      @(posedge clk);
      k++;
      if ((k % C) == 0) lat = 1'b0;
      else if (r && ((k % C) <= C - U - 1)) lat = 1'b1;
      @(negedge clk);
    end
    rd_done = 1'b0;
    cmd_wakeup = 1'b0;
  endtask

  // Pin pulse; returns at the falling edge after the restarting edge.
  task automatic pin_pulse();
    sync_n = 1'b0;
    @(negedge clk);
    sync_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1 reset state
    @(negedge clk);
    chk("R1 drdy", drdy_n, 1);
    chk("R1 mode", mode_o, 0);
    chk("R1 conv", conv_en, 1);
    chk("R1 osc", osc_en, 1);
    chk("R1 sif", sif_block, 0);
    chk("R1 clkout", clkout_en, 0);
    @(negedge clk);
    rst = 1'b0;
    track(6 * C, -1, "R1 R2");

    // R5 blocked interface, then R4 pin synchronization
    sync_n = 1'b0;
    @(negedge clk);
    chk("R5 sif low", sif_block, 1);
    cmd_standby = 1'b1;
    @(negedge clk);
    cmd_standby = 1'b0;
    chk("R5 cmd ignored", mode_o, 0);
    sync_n = 1'b1;
    @(negedge clk);
    chk("R5 sif high", sif_block, 0);
    track(3 * C, -1, "R4");

    // R11 long low stretch short of power-down
    pin_pulse();
    sync_n = 1'b0;
    repeat ((PD - 1) * C + 5) @(negedge clk);
    chk("R11 still run", mode_o, 0);
    sync_n = 1'b1;
    @(negedge clk);
    chk("R11 run after", mode_o, 0);
    track(2 * C, -1, "R11");

    // R6 halt command, R10 ignored commands
    cmd_sync = 1'b1;
    @(negedge clk);
    cmd_sync = 1'b0;
    chk("R6 halt mode", mode_o, 1);
    chk("R6 conv off", conv_en, 0);
    for (int i = 0; i < 2 * C; i++) begin
      if (i == 7) cmd_standby = 1'b1;
      if (i == 8) cmd_standby = 1'b0;
      @(negedge clk);
      if (i % 16 == 0) chk("R6 flag held", drdy_n, 1);
    end
    chk("R10 standby ignored in halt", mode_o, 1);
    cmd_wakeup = 1'b1;
    @(negedge clk);
    cmd_wakeup = 1'b0;
    chk("R6 wake mode", mode_o, 0);
    track(3 * C, C + 10, "R6 R10");

    // R7 standby
    cmd_standby = 1'b1;
    @(negedge clk);
    cmd_standby = 1'b0;
    chk("R7 mode", mode_o, 2);
    chk("R7 conv", conv_en, 0);
    chk("R7 osc", osc_en, 1);
    chk("R7 clkout on", clkout_en, 1);
    chk("R7 flag", drdy_n, 1);
    clkout_sel = 1'b0;
    @(negedge clk);
    chk("R7 clkout off", clkout_en, 0);
    clkout_sel = 1'b1;
    cmd_sync = 1'b1;
    @(negedge clk);
    cmd_sync = 1'b0;
    chk("R10 sync ignored in standby", mode_o, 2);
    chk("R7 clkout back", clkout_en, 1);
    cmd_wakeup = 1'b1;
    @(negedge clk);
    cmd_wakeup = 1'b0;
    chk("R7 wake mode", mode_o, 0);
    track(2 * C, -1, "R7");

    // R8 power-down
    pin_pulse();
    sync_n = 1'b0;
    repeat (PD * C - 1) @(negedge clk);
    chk("R8 before", mode_o, 0);
    @(negedge clk);
    chk("R8 mode", mode_o, 3);
    chk("R8 conv", conv_en, 0);
    chk("R8 osc", osc_en, 0);
    chk("R8 clkout", clkout_en, 0);
    chk("R8 flag", drdy_n, 1);
    cmd_wakeup = 1'b1;
    repeat (5) @(negedge clk);
    cmd_wakeup = 1'b0;
    chk("R8 stays", mode_o, 3);

    // R9 wake interval
    sync_n = 1'b1;
    @(negedge clk);
    chk("R9 wake mode", mode_o, 4);
    chk("R9 osc", osc_en, 1);
    chk("R9 clkout", clkout_en, 0);
    chk("R9 conv", conv_en, 0);
    repeat (W - 1) @(negedge clk);
    chk("R9 wake end", mode_o, 4);
    @(negedge clk);
    chk("R9 run", mode_o, 0);
    chk("R9 conv on", conv_en, 1);
    track(2 * C, -1, "R9");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule